// File: doc/BRIEF.md
# Dual-Edge Pin Change Interrupt Controller

This block watches two asynchronous external pins, such as a line-interface hook indicator or a tone-decoder data-valid flag. Each pin passes through a synchronizer. Any change of level on a pin, rising or falling, sets a sticky event bit for that pin. Every event bit has its own mask bit. A single level-sensitive interrupt output is high while at least one event bit is set and unmasked.

Host software uses a small register port with a two-bit address, a write strobe and a combinational read. Event bits are cleared by writing a 1 to them. The current synchronized level of each pin is readable in a separate read-only register. Software can therefore read the present state of a pin, for example to tell whether a handset is on or off hook, without losing any pending event.

After reset the block takes its first valid synchronized sample as the baseline. A pin that is already high when reset is released does not produce an event.

Top module: `pin_change_irq`

## Requirements
- R1: After reset, the event register (address 0) reads 0, the mask register (address 1) reads all ones over the pin bits, and `irq` is low.
- R2: A rising level on pin i sets bit i of the event register. The bit reads 1 after the third rising clock edge following the pin change.
- R3: A falling level on pin i also sets bit i of the event register, with the same three-edge latency as R2.
- R4: Bit i of the level register (address 2) shows the synchronized level of pin i. It follows the pin two rising clock edges after a change.
- R5: A write to address 0 clears every event bit whose write-data bit is 1 and leaves every bit whose write-data bit is 0 unchanged.
- R6: If a pin change is detected in the same cycle as a write that clears that pin's event bit, the bit stays set.
- R7: `irq` is high exactly when some event bit i is 1 and mask bit i is 0. The mask register is read/write at address 1, and a mask bit value of 1 blocks that pin.
- R8: A pin that holds a steady level from reset through the first synchronized sample produces no event.
- R9: Writes to the level register (address 2) and to the spare address 3 change no state, and a read of address 3 returns 0.
- R10: An event bit stays set while its pin keeps a steady level, until software clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| pin_in | input | NUM_PINS | Asynchronous external pins |
| reg_addr | input | 2 | Register select: 0 events, 1 mask, 2 level, 3 spare |
| reg_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr`, combinational, zero-extended |
| irq | output | 1 | Combined interrupt request, active high |

## Verification
On every cycle, the assertions check that a detected edge is a real change of the synchronized level and that every detected edge sets its event bit on the next cycle. They also check that an event bit never rises without a detected edge, that a set bit only clears through a write with no simultaneous edge, and that a fully masked block keeps `irq` low. The bench scenarios are the only place that shows the end-to-end cycle latencies from pin to level and from pin to event bit. They also cover the arming baseline after reset, the clear-versus-edge collision, and the absence of effect from writes to read-only and unused addresses. A seeded random sequence of pin changes, mask writes and clears is compared against a bench model of the register state.

// File: rtl/pin_change_irq_pkg.sv
package pin_change_irq_pkg;
  localparam int unsigned REG_ADDR_W = 2;

  typedef enum logic [REG_ADDR_W-1:0] {
    SEL_EVENT = 2'd0,
    SEL_MASK  = 2'd1,
    SEL_LEVEL = 2'd2,
    SEL_SPARE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/pci_rst_release.sv
// Asynchronous assert, synchronous release of the active-low reset.
module pci_rst_release #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/pin_sync_bank.sv
// Multi-flop synchronizer, one chain per pin.
module pin_sync_bank #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_async,
  output logic [WIDTH-1:0] pin_sync
);
  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] stage_d [STAGES];

  always_comb begin
    stage_d[0] = pin_async;
    for (int s = 1; s < STAGES; s++) stage_d[s] = stage_q[s-1];
  end

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_d[s];
      end
    end
  endgenerate

  assign pin_sync = stage_q[STAGES-1];
endmodule

// File: rtl/level_change_det.sv
// Detects any change of the synchronized level once the synchronizer is filled.
module level_change_det #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] level_i,
  output logic [WIDTH-1:0] change_o
);
  localparam int unsigned CNT_W = $clog2(STAGES + 1);
  localparam logic [CNT_W-1:0] FILL_LAST = CNT_W'(STAGES);

  logic [CNT_W-1:0] fill_q, fill_d;
  logic             fill_done;
  logic             armed_q, armed_d;
  logic [WIDTH-1:0] prev_q, prev_d;
  logic             prev_en;

  always_comb begin
    fill_done = (fill_q == FILL_LAST);
    fill_d    = fill_done ? fill_q : fill_q + 1'b1;
    prev_en   = fill_done;
    prev_d    = prev_en ? level_i : prev_q;
    armed_d   = armed_q | fill_done;
    change_o  = armed_q ? (level_i ^ prev_q) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q  <= '0;
      armed_q <= 1'b0;
      prev_q  <= '0;
    end else begin
      fill_q  <= fill_d;
      armed_q <= armed_d;
      prev_q  <= prev_d;
    end
  end

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_chk
      // R2 R3: a reported change is a real change against the previous cycle
      assert_change_is_real_R2: assert property (@(posedge clk) disable iff (!rst_n)
        change_o[i] |-> (level_i[i] != $past(level_i[i])));
    end
  endgenerate
endmodule

// File: rtl/event_status_reg.sv
// Sticky per-pin event bits with write-one-to-clear; set wins over clear.
module event_status_reg #(
  parameter int unsigned WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] change_i,
  input  logic [WIDTH-1:0] clear_i,
  output logic [WIDTH-1:0] status_o
);
  logic [WIDTH-1:0] status_q, status_d;
  logic             upd_en;

  always_comb begin
    upd_en   = |{change_i, clear_i};
    status_d = upd_en ? ((status_q & ~clear_i) | change_i) : status_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= status_d;
  end

  assign status_o = status_q;

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_chk
      assert_edge_sets_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        change_i[i] |=> status_q[i]);
      assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q[i] && !clear_i[i]) |=> status_q[i]);
      assert_clear_works_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q[i] && clear_i[i] && !change_i[i]) |=> !status_q[i]);
      assert_no_spurious_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_q[i]) |-> $past(change_i[i]));
    end
  endgenerate
endmodule

// File: rtl/pin_change_irq.sv
module pin_change_irq #(
  parameter int unsigned NUM_PINS    = 2,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_in,
  input  logic [1:0]          reg_addr,
  input  logic                reg_wr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  output logic                irq
);
  import pin_change_irq_pkg::*;

  logic                rst_n_s;
  logic [NUM_PINS-1:0] level_s;
  logic [NUM_PINS-1:0] change;
  logic [NUM_PINS-1:0] clear;
  logic [NUM_PINS-1:0] status;
  logic [NUM_PINS-1:0] mask_q, mask_d;
  logic                mask_en;
  reg_sel_e            sel;

  pci_rst_release #(.STAGES(2)) u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_n_s)
  );

  pin_sync_bank #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .pin_async (pin_in),
    .pin_sync  (level_s)
  );

  level_change_det #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_det (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .level_i  (level_s),
    .change_o (change)
  );

  event_status_reg #(.WIDTH(NUM_PINS)) u_evt (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .change_i (change),
    .clear_i  (clear),
    .status_o (status)
  );

  always_comb begin
    sel     = reg_sel_e'(reg_addr);
    clear   = (reg_wr && sel == SEL_EVENT) ? reg_wdata[NUM_PINS-1:0] : '0;
    mask_en = reg_wr && (sel == SEL_MASK);
    mask_d  = mask_en ? reg_wdata[NUM_PINS-1:0] : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) mask_q <= '1;
    else          mask_q <= mask_d;
  end

  always_comb begin
    reg_rdata = '0;
    unique case (sel)
      SEL_EVENT: reg_rdata[NUM_PINS-1:0] = status;
      SEL_MASK:  reg_rdata[NUM_PINS-1:0] = mask_q;
      SEL_LEVEL: reg_rdata[NUM_PINS-1:0] = level_s;
      SEL_SPARE: reg_rdata = '0;
      default:   reg_rdata = '0;
    endcase
  end

  assign irq = |(status & ~mask_q);

  generate
    if (DATA_W > NUM_PINS) begin : g_unused
      logic unused_wdata_hi;
      assign unused_wdata_hi = ^reg_wdata[DATA_W-1:NUM_PINS];
    end
  endgenerate

  assert_masked_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (&mask_q) |-> !irq);
  assert_mask_reset_R1: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(rst_n_s) |-> (&mask_q));
endmodule

// File: tb/pin_change_irq_test.sv
module pin_change_irq_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] pins;
  logic [1:0] addr;
  logic       wr;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       irq;

  int checks = 0;
  int errors = 0;

  logic [1:0] m_st, m_mk, m_lv;

  always #5 clk = ~clk;

  pin_change_irq uut (
    .clk(clk), .rst_n(rst_n), .pin_in(pins), .reg_addr(addr),
    .reg_wr(wr), .reg_wdata(wdata), .reg_rdata(rdata), .irq(irq)
  );

  function automatic logic exp_irq(logic [1:0] st, logic [1:0] mk);
    return |(st & ~mk);
  endfunction

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  task automatic wrreg(logic [1:0] a, logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    step();
    wr = 1'b0;
  endtask

  task automatic check_all(string req);
    logic [7:0] v;
    rd(2'd0, v); chk({req, " events"}, v, {6'd0, m_st});
    rd(2'd1, v); chk({req, " mask"},   v, {6'd0, m_mk});
    rd(2'd2, v); chk({req, " level"},  v, {6'd0, m_lv});
    chk({req, " irq"}, {7'd0, irq}, {7'd0, exp_irq(m_st, m_mk)});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; pins = 2'b01; addr = 2'd0; wr = 1'b0; wdata = '0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (10) step();
    // R1 and R8: pin0 high across reset produces no event
    m_st = 2'b00; m_mk = 2'b11; m_lv = 2'b01;
    check_all("R1/R8");

    // R2 rising on pin1; R4 level after two edges
    pins = 2'b11;
    step(); step();
    rd(2'd2, v); chk("R4 level after two edges", v, 8'h03);
    rd(2'd0, v); chk("R2 not yet set after two edges", v, 8'h00);
    step();
    m_lv = 2'b11; m_st = 2'b10;
    check_all("R2");

    // R7 masking
    wrreg(2'd1, 8'h00); m_mk = 2'b00; check_all("R7 unmasked");
    wrreg(2'd1, 8'h01); m_mk = 2'b01; check_all("R7 pin1 open");
    wrreg(2'd1, 8'h02); m_mk = 2'b10; check_all("R7 pin1 masked");

    // R5 write one to clear
    wrreg(2'd0, 8'h01); check_all("R5 zero bit untouched");
    wrreg(2'd0, 8'h02); m_st = 2'b00; check_all("R5 cleared");

    // R3 falling on pin0
    pins = 2'b10;
    repeat (3) step();
    m_lv = 2'b10; m_st = 2'b01; check_all("R3");

    // R10 sticky
    repeat (6) step();
    check_all("R10");

    // R6 edge coincident with clear on pin0
    pins = 2'b11;
    step(); step();
    wrreg(2'd0, 8'h01);
    m_lv = 2'b11; m_st = 2'b01; check_all("R6 set wins");
    wrreg(2'd0, 8'h01); m_st = 2'b00; check_all("R6 later clear");

    // R9 writes to read-only and spare addresses
    wrreg(2'd2, 8'hFF);
    wrreg(2'd3, 8'hFF);
    check_all("R9");
    rd(2'd3, v); chk("R9 spare reads zero", v, 8'h00);

    // random mix against model
    for (int n = 0; n < 300; n++) begin
      int op;
      logic [1:0] r;
      op = $urandom % 3;
      r  = 2'($urandom);
      if (op == 0) begin
        pins = r;
        repeat (3) step();
        m_st = m_st | (r ^ m_lv);
        m_lv = r;
        check_all("R2/R3/R4 random");
      end else if (op == 1) begin
        wrreg(2'd1, {6'd0, r}); m_mk = r;
        check_all("R7 random");
      end else begin
        wrreg(2'd0, {6'd0, r}); m_st = m_st & ~r;
        check_all("R5 random");
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule